// File: doc/BRIEF.md
# Power Mode Sequencer

This block moves a system between four operating modes: SLEEP, DOZE, SLOW and NORMAL. Software chooses the target by writing a three-bit mode field. The block does not jump straight from one mode to another. It steps through intermediate states that bring up the crystal oscillator, bring up the PLL and hand the clock selection from one source to the next. The select only moves once the destination source has reported that it is running.

The block drives a clock-source select and enables for the system clocks, the crystal oscillator and the PLL. It reports its current sequencer state and the mode field. A wake request on IRQ or FIQ ends SLEEP, and that wake also rewrites the mode field from SLEEP to DOZE. The oscillator, the PLL and the glitch-free clock multiplexer lie outside the block. They appear only as a stable flag, a lock flag and the select code. Each start-up wait has a timeout: when a source never reports ready, the sequencer falls back to the mode it came from and then tries again.

Top module: `pwr_mode_seq`

## Requirements
- R1: The mode field `mode_field` is written with `mode_wdata` in the cycle after `mode_wr` is sampled high. Bit 2 requests NORMAL, bit 1 requests SLOW, bit 0 requests DOZE, and 000 means SLEEP. When several bits are set, the highest one wins, so while NORMAL runs, the field 110 keeps it in NORMAL. State codes on `seq_state`: 0 SLEEP, 1 DOZE, 2 crystal start, 3 SLOW, 4 PLL start, 5 NORMAL, 6 leave PLL, 7 leave crystal. Source codes on `clk_src_sel`: 0 low-speed oscillator, 1 crystal, 2 PLL.
- R2: In SLEEP the system clocks are gated (`sys_clk_en`=0), the source is the low-speed oscillator, and the crystal and the PLL are both disabled.
- R3: In SLEEP, IRQ or FIQ high at a clock edge moves the state to DOZE at that edge. At the same edge the mode field becomes 001.
- R4: In DOZE the system clocks run (`sys_clk_en`=1) from the low-speed oscillator, and the crystal and the PLL are off.
- R5: DOZE enters SLEEP only when the mode field is 000 and `cpu_wfi` is high. With wait-for-interrupt and a non-zero field, or with a zero field and no wait-for-interrupt, the block stays in DOZE.
- R6: In DOZE, a SLOW or NORMAL request enters crystal start. There the crystal is enabled and the source stays low-speed. The state moves to SLOW, with the source set to crystal, at the first edge where `xtal_stable` is high.
- R7: In SLOW, the NORMAL bit enters PLL start. There the PLL is enabled and the source stays crystal. The state moves to NORMAL, with the source set to PLL, at the first edge where `pll_locked` is high. If neither the SLOW bit nor the NORMAL bit is set, SLOW enters leave-crystal (source still crystal) for one cycle and then DOZE.
- R8: In NORMAL, clearing the NORMAL bit enters leave-PLL. There the source stays PLL until an edge with `xtal_stable` high, and then the state becomes SLOW.
- R9: A start state that sees no ready flag for SETTLE_CYCLES cycles (16 by default) gives up at the 16th edge after entry. Crystal start returns to DOZE and PLL start returns to SLOW. A ready flag that arrives at that same edge wins over the timeout.
- R10: While reset is high, the state is SLOW, the source is crystal, and the mode field is 000.
- R11: A software write in the same cycle as a wake rewrite wins, and the field takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode field write value |
| irq | input | 1 | Normal wake interrupt |
| fiq | input | 1 | Fast wake interrupt |
| cpu_wfi | input | 1 | CPU waiting for interrupt |
| xtal_stable | input | 1 | Crystal oscillator running and stable |
| pll_locked | input | 1 | PLL locked |
| mode_field | output | 3 | Software-visible mode field |
| seq_state | output | 3 | Current sequencer state code |
| clk_src_sel | output | 2 | Clock-source select for the external multiplexer |
| sys_clk_en | output | 1 | CPU and bus clock enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |

## Verification
The sequencer is driven up and down the whole mode ladder. It goes from DOZE to SLOW to NORMAL and back again, which separates a correct handover from a select that moves before its source is ready. The ready flags are held low long enough to expire both timeouts, and in one case the flag arrives at the expiry edge, which shows which side wins. Entry to SLEEP is tried with wait-for-interrupt and the field each present alone and then together. Wake is tried on IRQ alone, and on FIQ together with a software write, which shows whether the write or the rewrite owns the field.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int MODE_W   = 3;
    localparam int BIT_DOZE = 0;
    localparam int BIT_SLOW = 1;
    localparam int BIT_NORM = 2;

    localparam logic [MODE_W-1:0] FIELD_SLEEP = 3'b000;
    localparam logic [MODE_W-1:0] FIELD_DOZE  = 3'b001;

    typedef enum logic [2:0] {
        ST_SLEEP   = 3'd0,
        ST_DOZE    = 3'd1,
        ST_XTAL_UP = 3'd2,
        ST_SLOW    = 3'd3,
        ST_PLL_UP  = 3'd4,
        ST_NORMAL  = 3'd5,
        ST_OFF_PLL = 3'd6,
        ST_OFF_XT  = 3'd7
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_LOW  = 2'd0,
        SRC_XTAL = 2'd1,
        SRC_PLL  = 2'd2
    } clk_src_t;

    typedef struct packed {
        clk_src_t src;
        logic     sys_en;
        logic     xtal_on;
        logic     pll_on;
    } clk_ctl_t;

    function automatic logic wants_pll(input logic [MODE_W-1:0] req);
        return req[BIT_NORM];
    endfunction

    function automatic logic wants_xtal(input logic [MODE_W-1:0] req);
        return req[BIT_NORM] | req[BIT_SLOW];
    endfunction

    function automatic clk_ctl_t clk_ctl_of(input seq_state_t st);
        clk_ctl_t c;
        case (st)
            ST_SLEEP:   c = '{src: SRC_LOW,  sys_en: 1'b0, xtal_on: 1'b0, pll_on: 1'b0};
            ST_DOZE:    c = '{src: SRC_LOW,  sys_en: 1'b1, xtal_on: 1'b0, pll_on: 1'b0};
            ST_XTAL_UP: c = '{src: SRC_LOW,  sys_en: 1'b1, xtal_on: 1'b1, pll_on: 1'b0};
            ST_SLOW:    c = '{src: SRC_XTAL, sys_en: 1'b1, xtal_on: 1'b1, pll_on: 1'b0};
            ST_PLL_UP:  c = '{src: SRC_XTAL, sys_en: 1'b1, xtal_on: 1'b1, pll_on: 1'b1};
            ST_NORMAL:  c = '{src: SRC_PLL,  sys_en: 1'b1, xtal_on: 1'b1, pll_on: 1'b1};
            ST_OFF_PLL: c = '{src: SRC_PLL,  sys_en: 1'b1, xtal_on: 1'b1, pll_on: 1'b1};
            default:    c = '{src: SRC_XTAL, sys_en: 1'b1, xtal_on: 1'b1, pll_on: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);

    // R9: the wait counter never runs past its limit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              wake,
    output logic [MODE_W-1:0] field
);
    always_ff @(posedge clk) begin
        if (rst) begin
            field <= FIELD_SLEEP;
        end else if (wr) begin
            field <= wdata;
        end else if (wake) begin
            field <= FIELD_DOZE;
        end
    end

    // R3: a wake with no write leaves the field at the DOZE code
    p_wake_rewrite_r3: assert property (@(posedge clk) disable iff (rst)
        (wake && !wr) |=> (field == FIELD_DOZE));

    // R11: a write wins over a wake in the same cycle
    p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (wake && wr) |=> (field == $past(wdata)));

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] req,
    input  logic              irq,
    input  logic              fiq,
    input  logic              cpu_wfi,
    input  logic              xtal_stable,
    input  logic              pll_locked,
    input  logic              settle_expired,
    output seq_state_t        state,
    output logic              settle_run,
    output logic              wake
);
    seq_state_t next_st;

    always_comb begin
        next_st = state;
        case (state)
            ST_SLEEP:   if (irq || fiq) next_st = ST_DOZE;
            ST_DOZE: begin
                if (wants_xtal(req))                    next_st = ST_XTAL_UP;
                else if (req == FIELD_SLEEP && cpu_wfi) next_st = ST_SLEEP;
            end
            ST_XTAL_UP: begin
                if (xtal_stable)         next_st = ST_SLOW;
                else if (settle_expired) next_st = ST_DOZE;
            end
            ST_SLOW: begin
                if (wants_pll(req))        next_st = ST_PLL_UP;
                else if (!wants_xtal(req)) next_st = ST_OFF_XT;
            end
            ST_PLL_UP: begin
                if (pll_locked)          next_st = ST_NORMAL;
                else if (settle_expired) next_st = ST_SLOW;
            end
            ST_NORMAL:  if (!wants_pll(req)) next_st = ST_OFF_PLL;
            ST_OFF_PLL: if (xtal_stable)     next_st = ST_SLOW;
            default:    next_st = ST_DOZE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_SLOW;
        else     state <= next_st;
    end

    assign settle_run = (state == ST_XTAL_UP) || (state == ST_PLL_UP);
    assign wake       = (state == ST_SLEEP) && (irq || fiq);

    // R3: an interrupt in SLEEP lands in DOZE
    p_sleep_wake_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && (irq || fiq)) |=> (state == ST_DOZE));

    // R5: SLEEP is entered only with a zero field and wait-for-interrupt
    p_sleep_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SLEEP && $past(state) == ST_DOZE) |->
            ($past(cpu_wfi) && $past(req) == FIELD_SLEEP));

    // R7: NORMAL is reached only after a lock report
    p_pll_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NORMAL && $past(state) == ST_PLL_UP) |-> $past(pll_locked));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [2:0] mode_wdata,
    input  logic       irq,
    input  logic       fiq,
    input  logic       cpu_wfi,
    input  logic       xtal_stable,
    input  logic       pll_locked,
    output logic [2:0] mode_field,
    output logic [2:0] seq_state,
    output logic [1:0] clk_src_sel,
    output logic       sys_clk_en,
    output logic       xtal_en,
    output logic       pll_en
);
    seq_state_t state;
    logic       settle_run;
    logic       settle_expired;
    logic       wake;
    clk_ctl_t   ctl;

    pwr_mode_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr    (mode_wr),
        .wdata (mode_wdata),
        .wake  (wake),
        .field (mode_field)
    );

    pwr_mode_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .req            (mode_field),
        .irq            (irq),
        .fiq            (fiq),
        .cpu_wfi        (cpu_wfi),
        .xtal_stable    (xtal_stable),
        .pll_locked     (pll_locked),
        .settle_expired (settle_expired),
        .state          (state),
        .settle_run     (settle_run),
        .wake           (wake)
    );

    pwr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (settle_run),
        .expired (settle_expired)
    );

    assign ctl         = clk_ctl_of(state);
    assign seq_state   = state;
    assign clk_src_sel = ctl.src;
    assign sys_clk_en  = ctl.sys_en;
    assign xtal_en     = ctl.xtal_on;
    assign pll_en      = ctl.pll_on;

    // R2: the system clocks are gated whenever the sequencer sleeps
    p_sleep_gated_r2: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 3'd0) |-> (!sys_clk_en && clk_src_sel == 2'd0 && !pll_en));

    // R8: a move of the select onto the crystal follows a stable report
    p_xtal_handover_r8: assert property (@(posedge clk) disable iff (rst)
        (clk_src_sel == 2'd1 && $past(clk_src_sel) != 2'd1) |-> $past(xtal_stable));

endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_wdata = 3'b000;
    logic       irq = 1'b0;
    logic       fiq = 1'b0;
    logic       cpu_wfi = 1'b0;
    logic       xtal_stable = 1'b0;
    logic       pll_locked = 1'b0;
    logic [2:0] mode_field;
    logic [2:0] seq_state;
    logic [1:0] clk_src_sel;
    logic       sys_clk_en;
    logic       xtal_en;
    logic       pll_en;

    localparam logic [2:0] S_SLEEP = 3'd0, S_DOZE = 3'd1, S_XUP = 3'd2, S_SLOW = 3'd3,
                           S_PUP = 3'd4, S_NORM = 3'd5, S_OFFP = 3'd6, S_OFFX = 3'd7;

    always #4 clk = ~clk;

    pwr_mode_seq u_dut (
        .clk         (clk),
        .rst         (rst),
        .mode_wr     (mode_wr),
        .mode_wdata  (mode_wdata),
        .irq         (irq),
        .fiq         (fiq),
        .cpu_wfi     (cpu_wfi),
        .xtal_stable (xtal_stable),
        .pll_locked  (pll_locked),
        .mode_field  (mode_field),
        .seq_state   (seq_state),
        .clk_src_sel (clk_src_sel),
        .sys_clk_en  (sys_clk_en),
        .xtal_en     (xtal_en),
        .pll_en      (pll_en)
    );

    typedef struct {
        logic [2:0] st;
        logic [2:0] fld;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // expected {src, sys_en, xtal_en, pll_en} per state, from R2, R4, R6, R7, R8
    function automatic logic [4:0] ctl_for(input logic [2:0] st);
        case (st)
            S_SLEEP: return {2'd0, 1'b0, 1'b0, 1'b0};
            S_DOZE:  return {2'd0, 1'b1, 1'b0, 1'b0};
            S_XUP:   return {2'd0, 1'b1, 1'b1, 1'b0};
            S_SLOW:  return {2'd1, 1'b1, 1'b1, 1'b0};
            S_PUP:   return {2'd1, 1'b1, 1'b1, 1'b1};
            S_NORM:  return {2'd2, 1'b1, 1'b1, 1'b1};
            S_OFFP:  return {2'd2, 1'b1, 1'b1, 1'b1};
            default: return {2'd1, 1'b1, 1'b1, 1'b0};
        endcase
    endfunction

    task automatic tick(input logic [2:0] st, input logic [2:0] fld, input string tag);
        exp_t e;
        e.st = st; e.fld = fld; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [2:0] v);
        mode_wr = 1'b1;
        mode_wdata = v;
    endtask

    // monitor: pops one expected item per edge and compares
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [10:0] act, want;
            e = exp_q.pop_front();
            act  = {seq_state, clk_src_sel, sys_clk_en, xtal_en, pll_en, mode_field};
            want = {e.st, ctl_for(e.st), e.fld};
            n_vec++;
            if (act !== want) begin
                n_bad++;
                $display("FAIL %s: {state,src,sys,xtal,pll,field} actual %b expected %b",
                         e.tag, act, want);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10: reset state
        tick(S_SLOW, 3'b000, "R10");
        tick(S_SLOW, 3'b000, "R10");
        rst = 1'b0;
        // R7: SLOW with empty field leaves via the crystal exit to DOZE
        tick(S_OFFX, 3'b000, "R7");
        tick(S_DOZE, 3'b000, "R7");
        // R5/R4: zero field without wfi stays in DOZE
        tick(S_DOZE, 3'b000, "R5");
        // R1: write DOZE code
        write(3'b001);
        tick(S_DOZE, 3'b001, "R1");
        mode_wr = 1'b0; cpu_wfi = 1'b1;
        // R5: wfi with non-zero field stays
        tick(S_DOZE, 3'b001, "R5");
        write(3'b000);
        tick(S_DOZE, 3'b000, "R1");
        mode_wr = 1'b0;
        tick(S_SLEEP, 3'b000, "R5");
        // R2: stays asleep and gated
        tick(S_SLEEP, 3'b000, "R2");
        cpu_wfi = 1'b0; irq = 1'b1;
        // R3: IRQ wakes and rewrites the field
        tick(S_DOZE, 3'b001, "R3");
        irq = 1'b0;
        tick(S_DOZE, 3'b001, "R4");
        write(3'b000);
        tick(S_DOZE, 3'b000, "R1");
        mode_wr = 1'b0; cpu_wfi = 1'b1;
        tick(S_SLEEP, 3'b000, "R5");
        cpu_wfi = 1'b0; fiq = 1'b1; write(3'b000);
        // R11: write beats the wake rewrite, FIQ still wakes
        tick(S_DOZE, 3'b000, "R11");
        fiq = 1'b0; mode_wr = 1'b0;
        tick(S_DOZE, 3'b000, "R4");
        // R6: crystal start
        write(3'b010);
        tick(S_DOZE, 3'b010, "R6");
        mode_wr = 1'b0;
        tick(S_XUP, 3'b010, "R6");
        tick(S_XUP, 3'b010, "R6");
        xtal_stable = 1'b1;
        tick(S_SLOW, 3'b010, "R6");
        tick(S_SLOW, 3'b010, "R6");
        // R7: PLL start
        write(3'b100);
        tick(S_SLOW, 3'b100, "R7");
        mode_wr = 1'b0;
        tick(S_PUP, 3'b100, "R7");
        tick(S_PUP, 3'b100, "R7");
        pll_locked = 1'b1;
        tick(S_NORM, 3'b100, "R7");
        tick(S_NORM, 3'b100, "R7");
        // R8: leave PLL, held until crystal stable
        xtal_stable = 1'b0; write(3'b010);
        tick(S_NORM, 3'b010, "R8");
        mode_wr = 1'b0;
        tick(S_OFFP, 3'b010, "R8");
        tick(S_OFFP, 3'b010, "R8");
        xtal_stable = 1'b1;
        tick(S_SLOW, 3'b010, "R8");
        // R9: PLL timeout
        pll_locked = 1'b0; write(3'b100);
        tick(S_SLOW, 3'b100, "R9");
        mode_wr = 1'b0;
        tick(S_PUP, 3'b100, "R9");
        for (int i = 0; i < 15; i++) tick(S_PUP, 3'b100, "R9");
        tick(S_SLOW, 3'b100, "R9");
        tick(S_PUP, 3'b100, "R9");
        pll_locked = 1'b1;
        tick(S_NORM, 3'b100, "R7");
        // full descent to DOZE
        write(3'b000);
        tick(S_NORM, 3'b000, "R8");
        mode_wr = 1'b0;
        tick(S_OFFP, 3'b000, "R8");
        tick(S_SLOW, 3'b000, "R8");
        tick(S_OFFX, 3'b000, "R7");
        tick(S_DOZE, 3'b000, "R7");
        // R9: crystal timeout, then ready at the expiry edge wins
        xtal_stable = 1'b0; pll_locked = 1'b0; write(3'b100);
        tick(S_DOZE, 3'b100, "R9");
        mode_wr = 1'b0;
        tick(S_XUP, 3'b100, "R9");
        for (int i = 0; i < 15; i++) tick(S_XUP, 3'b100, "R9");
        tick(S_DOZE, 3'b100, "R9");
        tick(S_XUP, 3'b100, "R9");
        for (int i = 0; i < 15; i++) tick(S_XUP, 3'b100, "R9");
        xtal_stable = 1'b1;
        tick(S_SLOW, 3'b100, "R9");
        tick(S_PUP, 3'b100, "R7");
        pll_locked = 1'b1;
        tick(S_NORM, 3'b100, "R7");
        // R1: NORMAL bit has priority over SLOW bit
        write(3'b110);
        tick(S_NORM, 3'b110, "R1");
        mode_wr = 1'b0;
        tick(S_NORM, 3'b110, "R1");
        tick(S_NORM, 3'b110, "R1");
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule